// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block takes an erase request, a start byte address and a byte length, over a single-cycle request and done handshake. It erases that region of a serial NOR flash by driving a single-lane SPI bus itself. It first checks the request against the device geometry. If the length covers the whole device, it issues one whole-device erase command. Otherwise it walks the region one erase block at a time.

Every erase command has the same preparation. The block reads the flash status register in repeated frames until the device stops reporting that a program or erase is in progress. It then sends a write-enable in a frame of its own. If the device stays busy for longer than a configurable number of clock cycles, the sequencer abandons the request and reports a timeout. The bit-level SPI engine runs in mode 0 and is part of the block.

A configuration flag selects the erase granularity. With the flag set, the block uses 4 KiB blocks and the small-block opcode. With it cleared, it uses the device's native sector size and the large-sector opcode. The number of address bytes follows from the device size.

Top module: `nor_erase_seq`

## Requirements
- R1: A request whose start plus length is larger than the device size completes with err high and err_code 1, and sends no SPI frame. This check takes precedence over R2.
- R2: A request whose length is not a whole multiple of the erase block size completes with err high and err_code 2, and sends no SPI frame.
- R3: A request whose length equals the device size sends exactly one erase frame. That frame is the single byte 0xC7 with no address. The request completes with err_code 0.
- R4: Any other request with a nonzero length sends one block-erase frame per block. The frame addresses are start, start+block, start+2·block and so on, and there are length/block frames in total. A zero length completes at once with err_code 0 and sends no frame.
- R5: With the small-block flag set, each block frame starts with opcode 0x20 and the block is 4096 bytes. With the flag cleared, the opcode is 0xD8 and the block is the sector size parameter.
- R6: Before every erase frame, the block sends one or more status frames. Each status frame is 0x05 followed by one read byte. The block repeats the status frame while bit 0 of the returned byte is 1 and ignores all other bits. Once bit 0 reads 0, the very next frame is the single byte 0x06, and the erase frame follows immediately after it.
- R7: A block address is sent most significant byte first. It takes 4 bytes when the device is larger than 16 MiB and 3 bytes otherwise.
- R8: If the device still reports busy after TIMEOUT_CYC cycles of a polling sequence, the request completes with err_code 3. No write-enable or erase frame follows, and chip select is high at completion.
- R9: A request is taken only while busy is low. A req_valid pulse while busy is high has no effect. done is high for exactly one cycle per accepted request, and err is high in that cycle exactly when err_code is nonzero.
- R10: Chip select is high and the SPI clock is low whenever no frame is in progress. Each byte is shifted most significant bit first. MOSI changes only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start-erase strobe, taken while busy is low |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with error, valid with done |
| err_code | output | 2 | 0 ok, 1 out of range, 2 length not block multiple, 3 busy timeout |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The case of interest is a new request that arrives while a multi-block erase is still running. Acceptance of a request and the per-block loop compete for the same address and length registers. The bench pulses req_valid with different arguments partway through a two-block erase. It then checks that the recorded frame stream holds only the first request's two block addresses and that exactly one done pulse appears. The timeout path also competes with a status reply, so a device model that never clears its busy bit is used to check that the abort leaves no write-enable or erase frame behind.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_RANGE   = 2'd1,
        ST_ALIGN   = 2'd2,
        ST_TIMEOUT = 2'd3
    } erase_status_e;

    typedef enum logic [1:0] {
        FR_POLL,
        FR_WREN,
        FR_CHIP,
        FR_BLOCK
    } frame_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FRAME,
        SQ_GAP,
        SQ_DONE
    } seq_state_e;

    localparam logic [7:0] OPC_STATUS   = 8'h05;
    localparam logic [7:0] OPC_WEN      = 8'h06;
    localparam logic [7:0] OPC_WHOLE    = 8'hC7;
    localparam logic [7:0] OPC_BLK_4K   = 8'h20;
    localparam logic [7:0] OPC_BLK_SECT = 8'hD8;

    localparam int unsigned SMALL_BLOCK = 4096;
    localparam int unsigned WIDE_ADDR_LIMIT = 16 * 1024 * 1024;

    // index of the final byte of a frame of the given kind
    function automatic logic [2:0] frame_last(frame_e k, int unsigned addr_bytes);
        case (k)
            FR_POLL:  frame_last = 3'd1;
            FR_BLOCK: frame_last = 3'(addr_bytes);
            default:  frame_last = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic             sclk_q;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_sh  <= {rx_sh[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = tx_sh[7];
    assign byte_done = done_q;
    assign rx_byte   = rx_sh;

    // R10
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= CNT_INIT;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> (cnt <= $past(cnt)));

    // R8
    reload_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && TIMEOUT_CYC > 0) |=> !expired);

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned DEV_BYTES    = 16 * 1024 * 1024,
    parameter int unsigned SECTOR_BYTES = 65536,
    parameter bit          SMALL_BLOCKS = 1'b1,
    parameter int unsigned TIMEOUT_CYC  = 1000000,
    parameter int unsigned HALF_DIV     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int unsigned LEN_W      = ADDR_W + 1;
    localparam int unsigned SUM_W      = ADDR_W + 2;
    localparam int unsigned BLK_BYTES  = SMALL_BLOCKS ? SMALL_BLOCK : SECTOR_BYTES;
    localparam int unsigned BLK_LOG    = $clog2(BLK_BYTES);
    localparam int unsigned ADDR_BYTES = (DEV_BYTES > WIDE_ADDR_LIMIT) ? 4 : 3;
    localparam logic [7:0]  BLK_OPC    = SMALL_BLOCKS ? OPC_BLK_4K : OPC_BLK_SECT;
    localparam logic [LEN_W-1:0]  BLK_L  = LEN_W'(BLK_BYTES);
    localparam logic [ADDR_W-1:0] BLK_A  = ADDR_W'(BLK_BYTES);
    localparam logic [LEN_W-1:0]  DEV_L  = LEN_W'(DEV_BYTES);
    localparam logic [SUM_W-1:0]  DEV_S  = SUM_W'(DEV_BYTES);

    seq_state_e        state;
    frame_e            kind;
    logic [2:0]        idx;
    logic              inflight;
    logic              whole_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [7:0]        last_rx;
    erase_status_e     code_q;

    logic              eng_start;
    logic              eng_done;
    logic [7:0]        eng_rx;
    logic [7:0]        tx_byte;
    logic              wd_reload;
    logic              wd_expired;

    // request screening
    logic [SUM_W-1:0]  req_end;
    logic              range_bad;
    logic              align_bad;
    logic              accept;

    always_comb begin
        req_end   = SUM_W'(req_addr) + SUM_W'(req_len);
        range_bad = req_end > DEV_S;
        align_bad = |req_len[BLK_LOG-1:0];
        accept    = (state == SQ_IDLE) && req_valid;
    end

    // byte selection for the frame in flight
    logic [ADDR_W+31:0] addr_wide;
    logic [5:0]         addr_sh;

    always_comb begin
        addr_sh   = 6'(8 * (ADDR_BYTES - int'(idx)));
        addr_wide = {32'b0, cur_addr} >> addr_sh;
        case (kind)
            FR_POLL:  tx_byte = (idx == 3'd0) ? OPC_STATUS : 8'h00;
            FR_WREN:  tx_byte = OPC_WEN;
            FR_CHIP:  tx_byte = OPC_WHOLE;
            default:  tx_byte = (idx == 3'd0) ? BLK_OPC : addr_wide[7:0];
        endcase
    end

    assign eng_start = (state == SQ_FRAME) && !inflight;
    assign wd_reload = (accept && !range_bad && !align_bad && req_len != '0)
                     || (state == SQ_GAP && kind == FR_BLOCK && remain != BLK_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            kind     <= FR_POLL;
            idx      <= '0;
            inflight <= 1'b0;
            whole_q  <= 1'b0;
            cur_addr <= '0;
            remain   <= '0;
            last_rx  <= '0;
            code_q   <= ST_OK;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        if (range_bad) begin
                            code_q <= ST_RANGE;
                            state  <= SQ_DONE;
                        end else if (align_bad) begin
                            code_q <= ST_ALIGN;
                            state  <= SQ_DONE;
                        end else if (req_len == '0) begin
                            code_q <= ST_OK;
                            state  <= SQ_DONE;
                        end else begin
                            code_q   <= ST_OK;
                            cur_addr <= req_addr;
                            remain   <= req_len;
                            whole_q  <= (req_len == DEV_L);
                            kind     <= FR_POLL;
                            idx      <= '0;
                            inflight <= 1'b0;
                            state    <= SQ_FRAME;
                        end
                    end
                end
                SQ_FRAME: begin
                    if (!inflight) begin
                        inflight <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        last_rx  <= eng_rx;
                        if (idx == frame_last(kind, ADDR_BYTES)) begin
                            idx   <= '0;
                            state <= SQ_GAP;
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                end
                SQ_GAP: begin
                    state <= SQ_FRAME;
                    case (kind)
                        FR_POLL: begin
                            if (!last_rx[0]) begin
                                kind <= FR_WREN;
                            end else if (wd_expired) begin
                                code_q <= ST_TIMEOUT;
                                state  <= SQ_DONE;
                            end
                        end
                        FR_WREN: kind <= whole_q ? FR_CHIP : FR_BLOCK;
                        FR_CHIP: state <= SQ_DONE;
                        default: begin
                            cur_addr <= cur_addr + BLK_A;
                            remain   <= remain - BLK_L;
                            if (remain == BLK_L) begin
                                state <= SQ_DONE;
                            end else begin
                                kind <= FR_POLL;
                            end
                        end
                    endcase
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    poll_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watchdog (
        .clk     (clk),
        .rst     (rst),
        .reload  (wd_reload),
        .run     (state != SQ_IDLE),
        .expired (wd_expired)
    );

    assign busy     = (state != SQ_IDLE);
    assign done     = (state == SQ_DONE);
    assign err_code = code_q;
    assign err      = done && (code_q != ST_OK);
    assign spi_cs_n = (state != SQ_FRAME);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R10
    cs_idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R8
    timeout_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 2'd3) |-> spi_cs_n);

    // R1
    reject_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (err_code == 2'd1 || err_code == 2'd2)) |-> !$past(busy));

endmodule

// File: tb/nor_erase_seq_test.sv
`timescale 1ns/1ps

module flash_model #(
    parameter int BUSY_POLLS = 2
) (
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    input  logic stuck,
    input  logic clr
);
    logic [7:0] fb [0:127][0:5];
    int         flen [0:127];
    bit         fbusy [0:127];
    int         nfr = 0;
    int         bitc = 0;
    int         bytec = 0;
    logic [7:0] sh = 8'h00;
    int         busy_left = 0;
    logic       cur_busy;
    logic [7:0] stat;

    initial miso = 1'b0;

    assign cur_busy = stuck || (busy_left > 0);
    assign stat = {1'b1, 5'b0, 1'b1, cur_busy};

    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            bitc  = 0;
            bytec = 0;
            sh    = 8'h00;
        end else if (!cs_n) begin
            sh   = {sh[6:0], mosi};
            bitc = bitc + 1;
            if (bitc % 8 == 0) begin
                if (bytec < 6 && nfr < 128) fb[nfr][bytec] = sh;
                bytec = bytec + 1;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && bitc >= 8 && bitc < 16 && nfr < 128 && fb[nfr][0] == 8'h05)
            miso = stat[15 - bitc];
        else
            miso = 1'b0;
    end

    always @(posedge cs_n or posedge clr) begin
        if (clr) begin
            nfr = 0;
        end else if (nfr < 128) begin
            flen[nfr]  = bytec;
            fbusy[nfr] = cur_busy;
            if (bytec > 0 && fb[nfr][0] == 8'h05 && busy_left > 0)
                busy_left = busy_left - 1;
            if (bytec > 0 && (fb[nfr][0] == 8'h20 || fb[nfr][0] == 8'hD8 || fb[nfr][0] == 8'hC7))
                busy_left = BUSY_POLLS;
            nfr = nfr + 1;
        end
    end
endmodule

module nor_erase_seq_test;
    localparam int SM_DEV  = 16384;
    localparam int SM_BLK  = 4096;
    localparam int BG_DEV  = 32 * 1024 * 1024;
    localparam int BG_BLK  = 65536;
    localparam int TMO     = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rv0 = 1'b0, rv4 = 1'b0;
    logic [31:0] r_addr = '0;
    logic [32:0] r_len = '0;
    logic        stuck = 1'b0, clr = 1'b0;

    logic        busy0, done0, err0, sclk0, cs0, mosi0, miso0;
    logic [1:0]  code0;
    logic        busy4, done4, err4, sclk4, cs4, mosi4, miso4;
    logic [1:0]  code4;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    nor_erase_seq #(.ADDR_W(32), .DEV_BYTES(SM_DEV), .SECTOR_BYTES(8192),
        .SMALL_BLOCKS(1'b1), .TIMEOUT_CYC(TMO), .HALF_DIV(2)) uut (
        .clk(clk), .rst(rst), .req_valid(rv0), .req_addr(r_addr), .req_len(r_len),
        .busy(busy0), .done(done0), .err(err0), .err_code(code0),
        .spi_sclk(sclk0), .spi_cs_n(cs0), .spi_mosi(mosi0), .spi_miso(miso0));

    nor_erase_seq #(.ADDR_W(32), .DEV_BYTES(BG_DEV), .SECTOR_BYTES(BG_BLK),
        .SMALL_BLOCKS(1'b0), .TIMEOUT_CYC(TMO), .HALF_DIV(2)) uut4 (
        .clk(clk), .rst(rst), .req_valid(rv4), .req_addr(r_addr), .req_len(r_len),
        .busy(busy4), .done(done4), .err(err4), .err_code(code4),
        .spi_sclk(sclk4), .spi_cs_n(cs4), .spi_mosi(mosi4), .spi_miso(miso4));

    flash_model fm0 (.sclk(sclk0), .cs_n(cs0), .mosi(mosi0), .miso(miso0), .stuck(stuck), .clr(clr));
    flash_model fm4 (.sclk(sclk4), .cs_n(cs4), .mosi(mosi4), .miso(miso4), .stuck(1'b0), .clr(clr));

    logic [7:0] g_fb [0:127][0:5];
    int         g_len [0:127];
    bit         g_busy [0:127];
    int         g_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic grab(input int which);
        if (which == 0) begin
            g_n = fm0.nfr;
            for (int f = 0; f < 128; f++) begin
                g_len[f] = fm0.flen[f]; g_busy[f] = fm0.fbusy[f];
                for (int b = 0; b < 6; b++) g_fb[f][b] = fm0.fb[f][b];
            end
        end else begin
            g_n = fm4.nfr;
            for (int f = 0; f < 128; f++) begin
                g_len[f] = fm4.flen[f]; g_busy[f] = fm4.fbusy[f];
                for (int b = 0; b < 6; b++) g_fb[f][b] = fm4.fb[f][b];
            end
        end
    endtask

    task automatic clear_model();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // issues a request, waits for done, returns the outcome
    task automatic issue(input int which, input longint addr, input longint len,
                         input int mid_pulse, output int got_code, output int got_err,
                         output int ndone);
        int cyc;
        bit seen;
        clear_model();
        r_addr = 32'(addr);
        r_len  = 33'(len);
        if (which == 0) rv0 = 1'b1; else rv4 = 1'b1;
        @(negedge clk);
        rv0 = 1'b0; rv4 = 1'b0;
        cyc = 0; seen = 0; ndone = 0; got_code = -1; got_err = -1;
        while (cyc < 200 || ((which == 0 ? busy0 : busy4) && cyc < 40000)) begin
            if (mid_pulse != 0 && cyc == mid_pulse) begin
                r_addr = 32'(addr + 2 * SM_BLK);
                r_len  = 33'(SM_BLK);
                rv0 = 1'b1;
            end else begin
                rv0 = 1'b0;
            end
            if ((which == 0 ? done0 : done4)) begin
                ndone++;
                if (!seen) begin
                    got_code = (which == 0) ? int'(code0) : int'(code4);
                    got_err  = (which == 0) ? int'(err0) : int'(err4);
                end
                seen = 1;
            end
            @(negedge clk);
            cyc++;
        end
        rv0 = 1'b0;
        chk(!(which == 0 ? busy0 : busy4), "R9", "idle after run", 0, 0);
        grab(which);
    endtask

    // checks the recorded frame stream of one request
    task automatic judge(input int which, input longint addr, input longint len, input int mid);
        int dev, blk, ab, op, exp_code, got_code, got_err, ndone, nexp, ei;
        longint ea;
        bit ok_seq;
        dev = (which == 0) ? SM_DEV : BG_DEV;
        blk = (which == 0) ? SM_BLK : BG_BLK;
        ab  = (dev > 16 * 1024 * 1024) ? 4 : 3;
        op  = (which == 0) ? 8'h20 : 8'hD8;
        if (addr + len > dev)      exp_code = 1;
        else if (len % blk != 0)   exp_code = 2;
        else                       exp_code = 0;
        issue(which, addr, len, mid, got_code, got_err, ndone);
        chk(ndone == 1, "R9", "done pulse count", ndone, 1);
        chk(got_code == exp_code, exp_code == 1 ? "R1" : (exp_code == 2 ? "R2" : "R4"),
            "err_code", got_code, exp_code);
        chk(got_err == (exp_code != 0), "R9", "err flag", got_err, exp_code != 0);
        if (exp_code != 0 || len == 0) nexp = 0;
        else if (len == dev)           nexp = 1;
        else                           nexp = int'(len / blk);
        if (exp_code != 0 || len == 0) begin
            chk(g_n == 0, exp_code == 0 ? "R4" : (exp_code == 1 ? "R1" : "R2"),
                "frames sent", g_n, 0);
            return;
        end
        ei = 0;
        ok_seq = 1;
        for (int f = 0; f < g_n; f++) begin
            if (g_fb[f][0] == 8'h05) begin
                if (g_len[f] != 2) ok_seq = 0;
                if (f + 1 < g_n && !g_busy[f] && g_fb[f+1][0] != 8'h06) ok_seq = 0;
                if (f + 1 < g_n && g_busy[f] && g_fb[f+1][0] != 8'h05) ok_seq = 0;
            end else if (g_fb[f][0] == 8'h06) begin
                if (g_len[f] != 1 || f < 1 || g_fb[f-1][0] != 8'h05 || g_busy[f-1]) ok_seq = 0;
            end else begin
                if (f < 2 || g_fb[f-1][0] != 8'h06) ok_seq = 0;
                if (len == dev) begin
                    chk(g_fb[f][0] == 8'hC7 && g_len[f] == 1, "R3", "whole erase frame",
                        {g_fb[f][0], 8'(g_len[f])}, 16'hC701);
                end else begin
                    ea = addr + longint'(ei) * blk;
                    chk(g_fb[f][0] == 8'(op), "R5", "block opcode", g_fb[f][0], op);
                    chk(g_len[f] == 1 + ab, "R7", "address byte count", g_len[f], 1 + ab);
                    for (int b = 1; b <= ab && b < 6; b++)
                        chk(g_fb[f][b] == 8'((ea >> (8 * (ab - b))) & 255), "R4",
                            "block address byte", g_fb[f][b], (ea >> (8 * (ab - b))) & 255);
                end
                ei++;
            end
        end
        chk(ok_seq, "R6", "poll/write-enable ordering", ok_seq, 1);
        chk(ei == nexp, len == dev ? "R3" : "R4", "erase frame count", ei, nexp);
    endtask

    initial begin
        int gc, ge, nd;
        int addrs [6];
        int lens [7];
        addrs = '{0, 4096, 8192, 12288, 16384, 100};
        lens  = '{0, 4096, 8192, 12288, 16384, 4095, 20480};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy0 && !done0 && !err0, "R9", "reset outputs", {busy0, done0, err0}, 0);
        chk(cs0 && !sclk0, "R10", "reset bus idle", {cs0, sclk0}, 2);

        // sweep over start and length on the small device (R1 R2 R3 R4 R5 R6 R7)
        for (int a = 0; a < 6; a++)
            for (int l = 0; l < 7; l++)
                judge(0, addrs[a], lens[l], 0);

        chk(cs0 && !sclk0, "R10", "bus idle between requests", {cs0, sclk0}, 2);

        // request pulsed mid-run is ignored (R9)
        judge(0, 0, 2 * SM_BLK, 300);

        // timeout while the device never becomes ready (R8)
        stuck = 1'b1;
        issue(0, 0, SM_BLK, 0, gc, ge, nd);
        chk(gc == 3 && ge == 1, "R8", "timeout code", gc, 3);
        chk(cs0, "R8", "chip select after abort", cs0, 1);
        begin
            bit only_polls;
            only_polls = 1;
            for (int f = 0; f < g_n; f++) if (g_fb[f][0] != 8'h05) only_polls = 0;
            chk(only_polls && g_n > 2, "R8", "only status frames", g_n, 3);
        end
        stuck = 1'b0;
        judge(0, 4096, SM_BLK, 0);

        // large device: sector opcode and wide addresses (R5 R7), whole device (R3)
        judge(1, 32'h0100_0000, 2 * BG_BLK, 0);
        judge(1, 32'h01FF_0000, BG_BLK, 0);
        judge(1, 0, BG_DEV, 0);
        judge(1, 32'h01FF_0000, 2 * BG_BLK, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule